// File: doc/BRIEF.md
# Multiply Lane with Result Merge

This block sits between decode and the memory stage of an in-order pipeline. An issued instruction token (valid, a multiply flag, two 32-bit operands and a destination tag) goes one of two ways. Non-multiply operations take a one-cycle execute lane. Here the ALU is modelled by a fixed function, the operand sum. Multiplies take a separate three-stage lane that runs next to the execute lane and never stops. This keeps the slow product off the execute stage's timing path.

Both lanes meet at one output slot toward the memory stage. When only one lane has a result, that result goes out. When both have one in the same cycle, the multiply result wins. The execute lane then holds its result and tag, and a stall line freezes the execute stage and everything before it. The held result leaves once the multiply lane has no valid result at its end. Branches resolve in the execute lane. A redirect input from that logic discards the token being issued in that cycle, so neither lane takes it in.

Top module: `mul_merge_lane`

## Requirements
- R1: A multiply result is the low 32 bits of the unsigned product of the two operands.
- R2: A non-multiply token accepted at a clock edge shows its result, the sum of the operands modulo 2^32, at the output after that same edge.
- R3: A multiply token accepted at clock edge k shows its result at the output after edge k+2, unless a reset intervenes.
- R4: `res_valid` is high exactly when at least one lane holds a valid result. When only one lane holds a valid result, that result and its tag go out.
- R5: When both lanes hold valid results in the same cycle, the multiply result goes out and `stall_up` is high. The execute lane keeps its result and tag unchanged and sends them out in the first cycle in which the multiply lane has no valid result at its end.
- R6: `res_from_mul` is 1 when the output comes from the multiply lane and 0 when it comes from the execute lane.
- R7: While `redirect` is high, the token at the issue inputs enters neither lane. Results already inside the lanes are unaffected.
- R8: Every result leaves with the destination tag that came with its token.
- R9: No token is accepted in a cycle in which `stall_up` is high, and the issuer holds it until a cycle without stall. The multiply lane advances every cycle whatever the stall state.
- R10: While `rst_n` is low, both lanes are empty, `res_valid` is 0 and `stall_up` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Issue token present |
| iss_mul | input | 1 | Token is a multiply |
| iss_a | input | 32 | First operand |
| iss_b | input | 32 | Second operand |
| iss_tag | input | 5 | Destination register tag |
| redirect | input | 1 | Branch mispredict: discard the issuing token |
| res_valid | output | 1 | Result slot toward memory stage is valid |
| res_data | output | 32 | Selected result |
| res_tag | output | 5 | Destination tag of the selected result |
| res_from_mul | output | 1 | 1 = multiply lane, 0 = execute lane |
| stall_up | output | 1 | Freeze execute stage and all earlier stages |

## Verification
Two things can fall in the same cycle. One is a multiply reaching the end of its lane. The other is an execute-lane result that must leave that same cycle. The bench provokes this by issuing a multiply, then one idle cycle, then an ALU op. It also issues a run of three multiplies followed by an ALU op, which keeps the execute result waiting for two cycles. A behavioural model records when each result is due and judges the output slot every cycle: which source wins, the stall line, the held tag and data, and the order in which results leave. Redirects raised during a stall and during idle cycles confirm that the discarded token never shows up.

// File: rtl/mml_pkg.sv
package mml_pkg;
  typedef enum logic {
    SRC_EXEC = 1'b0,
    SRC_MULT = 1'b1
  } lane_src_e;
endpackage

// File: rtl/mml_ex_lane.sv
module mml_ex_lane #(
  parameter int DW = 32,
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          hold,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [TW-1:0] tag,
  output logic          ex_v,
  output logic [DW-1:0] ex_d,
  output logic [TW-1:0] ex_t
);
  // stand-in for the execute ALU
  function automatic logic [DW-1:0] alu_fn(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_v <= 1'b0;
      ex_d <= '0;
      ex_t <= '0;
    end else if (!hold) begin
      ex_v <= take;
      if (take) begin
        ex_d <= alu_fn(op_a, op_b);
        ex_t <= tag;
      end
    end
  end

  // R5: a held result stays put
  a_r5_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (ex_v && $stable(ex_d) && $stable(ex_t)));
endmodule

// File: rtl/mml_mul_lane.sv
module mml_mul_lane #(
  parameter int DW = 32,
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [TW-1:0] tag,
  output logic          head_v,
  output logic          tail_v,
  output logic [DW-1:0] tail_d,
  output logic [TW-1:0] tail_t
);
  localparam int H   = DW / 2;
  localparam int NST = 3;

  // low half times low half, full width
  function automatic logic [DW-1:0] lo_prod(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW-1:0] xa, xb;
    xa = {{H{1'b0}}, a[H-1:0]};
    xb = {{H{1'b0}}, b[H-1:0]};
    return xa * xb;
  endfunction

  // cross terms, only the bits that land below bit DW
  function automatic logic [H-1:0] cross_prod(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [H-1:0] c0, c1;
    c0 = a[H-1:0] * b[DW-1:H];
    c1 = a[DW-1:H] * b[H-1:0];
    return c0 + c1;
  endfunction

  function automatic logic [DW-1:0] join_prod(input logic [DW-1:0] lo, input logic [H-1:0] cr);
    return lo + {cr, {H{1'b0}}};
  endfunction

  logic [NST-1:0] v_q;
  logic [TW-1:0]  t_q [NST];
  logic [DW-1:0]  s1_lo;
  logic [H-1:0]   s1_cr;
  logic [DW-1:0]  s2_p;
  logic [DW-1:0]  s3_p;

  for (genvar gs = 0; gs < NST; gs++) begin : g_stage
    if (gs == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q[gs] <= 1'b0;
          t_q[gs] <= '0;
        end else begin
          v_q[gs] <= take;
          t_q[gs] <= tag;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q[gs] <= 1'b0;
          t_q[gs] <= '0;
        end else begin
          v_q[gs] <= v_q[gs-1];
          t_q[gs] <= t_q[gs-1];
        end
      end
      // R9: the lane never stops, tag moves with it
      a_r9_lane_advances: assert property (@(posedge clk) disable iff (!rst_n)
        v_q[gs-1] |=> (v_q[gs] && t_q[gs] == $past(t_q[gs-1])));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_lo <= '0;
      s1_cr <= '0;
      s2_p  <= '0;
      s3_p  <= '0;
    end else begin
      s1_lo <= lo_prod(op_a, op_b);
      s1_cr <= cross_prod(op_a, op_b);
      s2_p  <= join_prod(s1_lo, s1_cr);
      s3_p  <= s2_p;
    end
  end

  assign head_v = v_q[0];
  assign tail_v = v_q[NST-1];
  assign tail_d = s3_p;
  assign tail_t = t_q[NST-1];
endmodule

// File: rtl/mml_merge.sv
module mml_merge
  import mml_pkg::*;
#(
  parameter int DW = 32,
  parameter int TW = 5
) (
  input  logic          ex_v,
  input  logic [DW-1:0] ex_d,
  input  logic [TW-1:0] ex_t,
  input  logic          mu_v,
  input  logic [DW-1:0] mu_d,
  input  logic [TW-1:0] mu_t,
  output logic          out_v,
  output logic [DW-1:0] out_d,
  output logic [TW-1:0] out_t,
  output lane_src_e     out_src,
  output logic          clash
);
  always_comb begin
    out_v   = ex_v | mu_v;
    clash   = ex_v & mu_v;
    out_src = mu_v ? SRC_MULT : SRC_EXEC;
    out_d   = mu_v ? mu_d : ex_d;
    out_t   = mu_v ? mu_t : ex_t;
  end
endmodule

// File: rtl/mul_merge_lane.sv
module mul_merge_lane
  import mml_pkg::*;
#(
  parameter int DW = 32,
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic          iss_mul,
  input  logic [DW-1:0] iss_a,
  input  logic [DW-1:0] iss_b,
  input  logic [TW-1:0] iss_tag,
  input  logic          redirect,
  output logic          res_valid,
  output logic [DW-1:0] res_data,
  output logic [TW-1:0] res_tag,
  output logic          res_from_mul,
  output logic          stall_up
);
  logic          take_any, take_ex, take_mul;
  logic          ex_v, mu_head_v, mu_v;
  logic [DW-1:0] ex_d, mu_d;
  logic [TW-1:0] ex_t, mu_t;
  lane_src_e     src;

  assign take_any = iss_valid && !stall_up && !redirect;
  assign take_ex  = take_any && !iss_mul;
  assign take_mul = take_any && iss_mul;

  mml_ex_lane #(.DW(DW), .TW(TW)) u_ex (
    .clk(clk), .rst_n(rst_n), .take(take_ex), .hold(stall_up),
    .op_a(iss_a), .op_b(iss_b), .tag(iss_tag),
    .ex_v(ex_v), .ex_d(ex_d), .ex_t(ex_t)
  );

  mml_mul_lane #(.DW(DW), .TW(TW)) u_mul (
    .clk(clk), .rst_n(rst_n), .take(take_mul),
    .op_a(iss_a), .op_b(iss_b), .tag(iss_tag),
    .head_v(mu_head_v), .tail_v(mu_v), .tail_d(mu_d), .tail_t(mu_t)
  );

  mml_merge #(.DW(DW), .TW(TW)) u_merge (
    .ex_v(ex_v), .ex_d(ex_d), .ex_t(ex_t),
    .mu_v(mu_v), .mu_d(mu_d), .mu_t(mu_t),
    .out_v(res_valid), .out_d(res_data), .out_t(res_tag),
    .out_src(src), .clash(stall_up)
  );

  assign res_from_mul = (src == SRC_MULT);

  // R5: multiply wins a clash and the upstream freezes
  a_r5_mul_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_v && mu_v) |-> (res_from_mul && stall_up && res_tag == mu_t));

  // R7: a redirected token enters neither lane
  a_r7_redirect_no_mul: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !mu_head_v);
  a_r7_redirect_no_ex: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !stall_up) |=> !ex_v);

  // R9: nothing enters the multiply lane during a stall
  a_r9_stall_blocks_mul: assert property (@(posedge clk) disable iff (!rst_n)
    stall_up |=> !mu_head_v);
endmodule

// File: tb/mul_merge_lane_bench.sv
`timescale 1ns/1ps
module mul_merge_lane_bench;
  localparam int DW = 32;
  localparam int TW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          iss_valid, iss_mul, redirect;
  logic [DW-1:0] iss_a, iss_b;
  logic [TW-1:0] iss_tag;
  logic          res_valid, res_from_mul, stall_up;
  logic [DW-1:0] res_data;
  logic [TW-1:0] res_tag;

  always #4 clk = ~clk;

  mul_merge_lane #(.DW(DW), .TW(TW)) u_mul_merge_lane (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_mul(iss_mul),
    .iss_a(iss_a), .iss_b(iss_b), .iss_tag(iss_tag), .redirect(redirect),
    .res_valid(res_valid), .res_data(res_data), .res_tag(res_tag),
    .res_from_mul(res_from_mul), .stall_up(stall_up)
  );

  int n_run = 0;
  int n_fail = 0;
  int win = 0;
  bit done = 0;

  // model: multiply results keyed by the window they are due in
  logic [DW-1:0] due_d [int];
  logic [TW-1:0] due_t [int];
  logic          mex_v = 1'b0;
  logic [DW-1:0] mex_d = '0;
  logic [TW-1:0] mex_t = '0;

  function automatic void check(string req, string what, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endfunction

  function automatic logic [DW-1:0] ref_mul(logic [DW-1:0] a, logic [DW-1:0] b);
    logic [63:0] p;
    p = {32'b0, a} * {32'b0, b};
    return p[DW-1:0];
  endfunction

  task automatic window_check();
    bit mv, ev;
    mv = due_d.exists(win);
    ev = mv || mex_v;
    check("R4,R7,R9", "res_valid", res_valid, ev);
    check("R5", "stall_up", stall_up, mv && mex_v);
    if (ev) begin
      check("R6", "res_from_mul", res_from_mul, mv);
      if (mv) begin
        check("R1,R3", "mul data", res_data, due_d[win]);
        check("R8", "mul tag", res_tag, due_t[win]);
      end else begin
        check("R2,R5", "exec data", res_data, mex_d);
        check("R8", "exec tag", res_tag, mex_t);
      end
    end
  endtask

  // one token; held across stall cycles as R9 demands
  task automatic issue(bit v, bit m, logic [DW-1:0] a, logic [DW-1:0] b,
                       logic [TW-1:0] t, bit r);
    bit st, acc, again;
    again = 1'b1;
    while (again) begin
      @(negedge clk);
      window_check();
      iss_valid = v; iss_mul = m; iss_a = a; iss_b = b; iss_tag = t; redirect = r;
      st  = due_d.exists(win) && mex_v;
      acc = v && !st && !r;
      if (acc && m) begin
        due_d[win+3] = ref_mul(a, b);
        due_t[win+3] = t;
      end
      if (!st) begin
        mex_v = acc && !m;
        if (acc && !m) begin
          mex_d = a + b;
          mex_t = t;
        end
      end
      if (due_d.exists(win)) begin
        due_d.delete(win);
        due_t.delete(win);
      end
      win++;
      again = v && st && !r;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) issue(0, 0, '0, '0, '0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    iss_valid = 0; iss_mul = 0; iss_a = '0; iss_b = '0; iss_tag = '0; redirect = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      // R10: lanes empty while reset is held
      check("R10", "res_valid in reset", res_valid, 0);
      check("R10", "stall_up in reset", stall_up, 0);
    end
    rst_n = 1'b1;
    win = 0;

    // R2: single ALU op
    issue(1, 0, 32'd5, 32'd7, 5'd3, 0);
    idle(4);
    // R1, R3: largest operands
    issue(1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd9, 0);
    idle(4);
    issue(1, 1, 32'h8000_0000, 32'd2, 5'd10, 0);
    issue(1, 0, 32'hFFFF_FFFF, 32'd1, 5'd11, 0);
    idle(4);
    // R5: multiply, gap, ALU op meet at the output
    issue(1, 1, 32'h1234_5678, 32'h9ABC_DEF0, 5'd1, 0);
    idle(1);
    issue(1, 0, 32'd100, 32'd23, 5'd2, 0);
    issue(1, 0, 32'd1, 32'd1, 5'd4, 0);
    idle(4);
    // R5, R9: three multiplies then ALU op, held two cycles
    issue(1, 1, 32'd3, 32'd4, 5'd5, 0);
    issue(1, 1, 32'd6, 32'd7, 5'd6, 0);
    issue(1, 1, 32'h0001_0000, 32'h0001_0000, 5'd7, 0);
    issue(1, 0, 32'd8, 32'd9, 5'd8, 0);
    issue(1, 1, 32'd11, 32'd13, 5'd12, 0);
    idle(5);
    // R7: redirected multiply and ALU op vanish
    issue(1, 1, 32'd50, 32'd60, 5'd13, 1);
    issue(1, 0, 32'd50, 32'd60, 5'd14, 1);
    idle(4);
    // R7 during a stall: token offered while stalled is dropped
    issue(1, 1, 32'd2, 32'd3, 5'd15, 0);
    idle(1);
    issue(1, 0, 32'd4, 32'd4, 5'd16, 0);
    issue(1, 1, 32'd9, 32'd9, 5'd17, 1);
    idle(4);

    // mixed traffic
    for (int k = 0; k < 3000; k++) begin
      bit v, m, r;
      logic [DW-1:0] a, b;
      int sel;
      v = ($urandom_range(9) < 7);
      m = ($urandom_range(9) < 4);
      r = ($urandom_range(19) == 0);
      sel = $urandom_range(7);
      a = (sel == 0) ? 32'hFFFF_FFFF : (sel == 1) ? 32'h0 : $urandom;
      b = (sel == 2) ? 32'hFFFF_FFFF : (sel == 3) ? 32'h8000_0000 : $urandom;
      issue(v, m, a, b, TW'($urandom), r);
    end
    idle(6);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule